// File: doc/BRIEF.md
# Vectored Interrupt Controller with Threshold

This block collects 32 external interrupt lines next to a small processor core and presents the single most urgent one as a vectored request. Software programs it through a simple register port: enable, pending and wakeup state each have a write-one-to-set and a write-one-to-clear address. There is a read-only in-service (active) mask, a write-one-to-set secure mask, one priority field per line and a threshold register. A line whose input is high latches as pending. The arbiter picks, among pending and enabled lines, the one with the lowest priority value, and the lowest line number on a tie. The request goes to the core as vector `32 + line`.

The request output follows valid/ready rules. `irq_valid` together with `irq_vec` and `irq_prio` offer the current winner. The core accepts it by holding `irq_ready` high at a clock edge where `irq_valid` is high. Before acceptance the offer is not held: a more urgent arrival, a clear, or a threshold change may change the vector or drop `irq_valid`. `irq_ready` while `irq_valid` is low has no effect. End of service is a plain strobe, `eoi_valid` with `eoi_id`. The register port has no back-pressure: a write takes effect at the clock edge that samples it, and read data returns one cycle after the read. `wake_req` rises whenever a pending line has its wakeup bit set, whether or not that line is enabled.

Register word addresses on `bus_addr`: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 wakeup-set, 5 wakeup-clear, 6 active (read-only), 7 secure-set, 8 threshold, 16 to 23 priority words. Unmapped addresses read as zero.

Top module: `ivc_top`

## Requirements
- R1: A write of 1 to a bit at address 0 enables that line, and a write of 1 at address 1 disables it. Zero bits leave the enable state unchanged. A read at either address returns the enable mask.
- R2: A line whose `irq_lines` bit is high at a clock edge becomes pending. A write of 1 at address 2 sets pending and a write of 1 at address 3 clears it. A read at 2 or 3 returns the pending mask. In a cycle where both a set and a clear reach the same bit, the clear wins.
- R3: A write of 1 at address 4 sets a line's wakeup bit and a write of 1 at address 5 clears it. A read at 4 or 5 returns the wakeup mask. `wake_req` is high exactly when some line is both pending and wakeup-enabled, whatever its enable bit.
- R4: Line n has an 8-bit priority field in word 16+n/4 at bits (n mod 4)*8+7 down to (n mod 4)*8. Only the top 2 bits of each field are stored, and the low 6 bits read as zero.
- R5: `irq_valid` is high when some line is pending and enabled and the threshold lets it pass. The offer is the line with the smallest 2-bit priority value, the lowest line number on ties. `irq_vec` = 32 + line and `irq_prio` = its priority value.
- R6: Threshold register (address 8): bit 31 is the enable, bits 15:8 a vector value that is stored and read back, and bits 7:6 the priority threshold. While enabled, a request is offered only if its priority value is strictly below the threshold. Otherwise it stays pending.
- R7: An accepted request clears that line's pending bit and sets its active bit (address 6) at the accepting edge. If the input is still high, the line is pending again one cycle later.
- R8: `eoi_valid` clears active bit `eoi_id`. If an acceptance of the same line falls in the same cycle, the active bit stays set.
- R9: Writes to address 6 have no effect. A write of 1 at address 7 marks a line secure, zero bits have no effect, and a read at 7 returns the secure mask.
- R10: After reset all masks, priorities and the threshold are zero, and `irq_valid`, `wake_req` and `rd_valid` are low.
- R11: A read (`bus_valid` high, `bus_write` low) returns `rd_valid` high with `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq_lines | input | 32 | Level interrupt inputs |
| irq_valid | output | 1 | Request offered to the core |
| irq_ready | input | 1 | Core accepts the offered request |
| irq_vec | output | 8 | Vector number of the offer (32 + line) |
| irq_prio | output | 2 | Priority value of the offer |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | 5 | Line whose service ends |
| wake_req | output | 1 | Wakeup request |

## Verification
Two pairs of functions can land on the same line in the same cycle. The first is the core's acceptance and a software pending-set write. The bench drives `irq_ready` and the pending-set write on one edge, then reads back a clear pending bit and a set active bit. The second is acceptance and end of service for the same line. The bench pulses both together and expects the active bit to survive, then confirms a lone end-of-service clears it.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_LINES  = 32;
  localparam int ID_W       = $clog2(NUM_LINES);
  localparam int PRIO_W     = 2;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam int VEC_W      = 8;
  localparam int VEC_BASE   = 32;
  localparam int LANES      = DATA_W / 8;
  localparam int PRIO_WORDS = NUM_LINES / LANES;

  localparam logic [ADDR_W-1:0] A_EN_SET = 6'd0;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 6'd1;
  localparam logic [ADDR_W-1:0] A_PD_SET = 6'd2;
  localparam logic [ADDR_W-1:0] A_PD_CLR = 6'd3;
  localparam logic [ADDR_W-1:0] A_WK_SET = 6'd4;
  localparam logic [ADDR_W-1:0] A_WK_CLR = 6'd5;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 6'd6;
  localparam logic [ADDR_W-1:0] A_SECURE = 6'd7;
  localparam logic [ADDR_W-1:0] A_THRESH = 6'd8;
  localparam logic [ADDR_W-1:0] A_PRIO0  = 6'd16;
endpackage

// File: rtl/ivc_regfile.sv
module ivc_regfile
  import ivc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_LINES-1:0]             en,
  output logic [NUM_LINES-1:0]             wmask,
  output logic [NUM_LINES-1:0]             secure,
  output logic                             thr_en,
  output logic [7:0]                       thr_vec,
  output logic [PRIO_W-1:0]                thr_prio,
  output logic [NUM_LINES-1:0][PRIO_W-1:0] prio
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= '0;
      wmask    <= '0;
      secure   <= '0;
      thr_en   <= 1'b0;
      thr_vec  <= '0;
      thr_prio <= '0;
    end else if (wr) begin
      case (addr)
        A_EN_SET: en     <= en | wdata;
        A_EN_CLR: en     <= en & ~wdata;
        A_WK_SET: wmask  <= wmask | wdata;
        A_WK_CLR: wmask  <= wmask & ~wdata;
        A_SECURE: secure <= secure | wdata;
        A_THRESH: begin
          thr_en   <= wdata[31];
          thr_vec  <= wdata[15:8];
          thr_prio <= wdata[7 -: PRIO_W];
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    localparam int WORD = i / LANES;
    localparam int LANE = i % LANES;
    localparam logic [ADDR_W-1:0] MY_ADDR = A_PRIO0 + ADDR_W'(WORD);
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio[i] <= '0;
      else if (wr && addr == MY_ADDR)
        prio[i] <= wdata[LANE*8+7 -: PRIO_W];
    end
  end

  p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EN_SET) |=> ((en & $past(wdata)) == $past(wdata)));
  p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EN_CLR) |=> ((en & $past(wdata)) == '0));
endmodule

// File: rtl/ivc_track.sv
module ivc_track
  import ivc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] sw_set,
  input  logic [NUM_LINES-1:0] sw_clr,
  input  logic                 ack,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 eoi,
  input  logic [ID_W-1:0]      eoi_id,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] active
);
  logic [NUM_LINES-1:0] ack_mask, eoi_mask;

  always_comb begin
    ack_mask = '0;
    eoi_mask = '0;
    if (ack) ack_mask[ack_id] = 1'b1;
    if (eoi) eoi_mask[eoi_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      active <= '0;
    end else begin
      pend   <= (pend | lines | sw_set) & ~(sw_clr | ack_mask);
      active <= (active & ~eoi_mask) | ack_mask;
    end
  end

  p_ack_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (active[$past(ack_id)] && !pend[$past(ack_id)]));
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && ack_id == eoi_id)) |=> !active[$past(eoi_id)]);
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
(
  input  logic [NUM_LINES-1:0]             pend,
  input  logic [NUM_LINES-1:0]             en,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  input  logic                             thr_en,
  input  logic [PRIO_W-1:0]                thr_prio,
  output logic                             valid,
  output logic [ID_W-1:0]                  win_id,
  output logic [PRIO_W-1:0]                win_prio
);
  logic [NUM_LINES-1:0] cand;
  logic                 found;

  assign cand = pend & en;

  // Scan from the top line down; "<=" lets a lower line take an equal priority.
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i] <= win_prio)) begin
        found    = 1'b1;
        win_id   = ID_W'(i);
        win_prio = prio[i];
      end
    end
  end

  assign valid = found && (!thr_en || win_prio < thr_prio);
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [31:0]       irq_lines,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [7:0]        irq_vec,
  output logic [1:0]        irq_prio,
  input  logic              eoi_valid,
  input  logic [4:0]        eoi_id,
  output logic              wake_req
);
  logic                             wr, rd;
  logic [NUM_LINES-1:0]             en, wmask, secure, pend, active;
  logic [NUM_LINES-1:0]             sw_set, sw_clr;
  logic                             thr_en;
  logic [7:0]                       thr_vec;
  logic [PRIO_W-1:0]                thr_prio;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
  logic                             ack;
  logic [ID_W-1:0]                  win_id;
  logic [DATA_W-1:0]                rd_next;

  assign wr     = bus_valid && bus_write;
  assign rd     = bus_valid && !bus_write;
  assign sw_set = (wr && bus_addr == A_PD_SET) ? bus_wdata : '0;
  assign sw_clr = (wr && bus_addr == A_PD_CLR) ? bus_wdata : '0;
  assign ack    = irq_valid && irq_ready;

  ivc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata),
    .en(en), .wmask(wmask), .secure(secure), .thr_en(thr_en),
    .thr_vec(thr_vec), .thr_prio(thr_prio), .prio(prio)
  );

  ivc_track u_track (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .sw_set(sw_set),
    .sw_clr(sw_clr), .ack(ack), .ack_id(win_id), .eoi(eoi_valid),
    .eoi_id(eoi_id), .pend(pend), .active(active)
  );

  ivc_arbiter u_arb (
    .pend(pend), .en(en), .prio(prio), .thr_en(thr_en), .thr_prio(thr_prio),
    .valid(irq_valid), .win_id(win_id), .win_prio(irq_prio)
  );

  assign irq_vec  = VEC_W'(VEC_BASE) + VEC_W'(win_id);
  assign wake_req = |(pend & wmask);

  function automatic logic [DATA_W-1:0] prio_word(input int w,
      input logic [NUM_LINES-1:0][PRIO_W-1:0] p);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++)
      r[l*8+7 -: PRIO_W] = p[w*LANES+l];
    return r;
  endfunction

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_EN_SET, A_EN_CLR: rd_next = en;
      A_PD_SET, A_PD_CLR: rd_next = pend;
      A_WK_SET, A_WK_CLR: rd_next = wmask;
      A_ACTIVE:           rd_next = active;
      A_SECURE:           rd_next = secure;
      A_THRESH:           rd_next = {thr_en, 15'd0, thr_vec, thr_prio, {(8-PRIO_W){1'b0}}};
      default: begin
        for (int w = 0; w < PRIO_WORDS; w++)
          if (bus_addr == A_PRIO0 + ADDR_W'(w)) rd_next = prio_word(w, prio);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_next : '0;
    end
  end

  p_offer_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend[win_id] && en[win_id]));
  p_thr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && thr_en) |-> (irq_prio < thr_prio));
  p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
endmodule

// File: tb/test_ivc_top.sv
module test_ivc_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, irq_lines = '0;
  logic        irq_ready = 0, eoi_valid = 0;
  logic [4:0]  eoi_id = '0;
  logic        rd_valid, irq_valid, wake_req;
  logic [31:0] rd_data;
  logic [7:0]  irq_vec;
  logic [1:0]  irq_prio;
  int n_cmp = 0, n_bad = 0;

  ivc_top i_ivc_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_lines(irq_lines), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vec(irq_vec), .irq_prio(irq_prio),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .wake_req(wake_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk("R11 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic offer(input string req, input logic v, input logic [7:0] vec, input logic [1:0] p);
    chk({req, " valid"}, {31'd0, irq_valid}, {31'd0, v});
    if (v) begin
      chk({req, " vec"}, {24'd0, irq_vec}, {24'd0, vec});
      chk({req, " prio"}, {30'd0, irq_prio}, {30'd0, p});
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 irq_valid", {31'd0, irq_valid}, 0);
    chk("R10 wake_req", {31'd0, wake_req}, 0);
    chk("R10 rd_valid", {31'd0, rd_valid}, 0);
    rd(6'd0, d); chk("R10 enable", d, 0);
    rd(6'd8, d); chk("R10 threshold", d, 0);
    tick(); chk("R11 rd_valid drops", {31'd0, rd_valid}, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(6'd0, 32'h0000_00F0);
    wr(6'd0, 32'h0);
    rd(6'd0, d); chk("R1 set", d, 32'h0000_00F0);
    wr(6'd1, 32'h0000_0030);
    rd(6'd1, d); chk("R1 clear", d, 32'h0000_00C0);
    wr(6'd1, 32'hFFFF_FFFF);
    rd(6'd0, d); chk("R1 all clear", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(6'd17, 32'hFFFF_FFFF);
    rd(6'd17, d); chk("R4 top bits", d, 32'hC0C0_C0C0);
    wr(6'd17, 32'h1234_5678);
    rd(6'd17, d); chk("R4 lanes", d, 32'h0000_4040);
    wr(6'd17, 32'h0);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(6'd16, 32'h4040_4040);
    wr(6'd18, 32'h0000_C000);
    wr(6'd0, 32'h0000_020C);
    wr(6'd2, 32'h0000_020C);
    rd(6'd2, d); chk("R2 pend set", d, 32'h0000_020C);
    offer("R5 tie low line", 1, 8'd34, 2'd1);
    wr(6'd18, 32'h0);
    offer("R5 most urgent", 1, 8'd41, 2'd0);
    wr(6'd3, 32'hFFFF_FFFF);
    rd(6'd3, d); chk("R2 pend clear", d, 0);
    offer("R5 none", 0, 0, 0);
    wr(6'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(6'd17, 32'h0000_8000);
    wr(6'd0, 32'h20);
    wr(6'd2, 32'h20);
    offer("R5 line5", 1, 8'd37, 2'd2);
    wr(6'd8, 32'h8000_2580);
    offer("R6 masked", 0, 0, 0);
    rd(6'd2, d); chk("R6 still pending", d, 32'h20);
    rd(6'd8, d); chk("R6 readback", d, 32'h8000_2580);
    wr(6'd8, 32'h8000_25C0);
    offer("R6 passes", 1, 8'd37, 2'd2);
    wr(6'd8, 32'h0000_0080);
    offer("R6 disabled", 1, 8'd37, 2'd2);
    wr(6'd8, 32'h0);
    wr(6'd3, 32'h20);
    wr(6'd1, 32'h20);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(6'd2, 32'h80);
    offer("R3 disabled line", 0, 0, 0);
    chk("R3 no wake", {31'd0, wake_req}, 0);
    wr(6'd4, 32'h80);
    chk("R3 wake masked line", {31'd0, wake_req}, 1);
    rd(6'd4, d); chk("R3 mask", d, 32'h80);
    wr(6'd5, 32'h80);
    chk("R3 wake off", {31'd0, wake_req}, 0);
    rd(6'd5, d); chk("R3 mask clear", d, 0);
    wr(6'd3, 32'h80);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(6'd0, 32'h40);
    irq_lines = 32'h40;
    tick();
    offer("R7 level", 1, 8'd38, 2'd0);
    irq_ready = 1; tick(); irq_ready = 0;
    offer("R7 cleared", 0, 0, 0);
    tick();
    offer("R7 re-pend", 1, 8'd38, 2'd0);
    irq_lines = '0;
    rd(6'd6, d); chk("R7 active", d, 32'h40);
    irq_ready = 1; tick(); irq_ready = 0;
    tick();
    offer("R7 drained", 0, 0, 0);
    eoi_valid = 1; eoi_id = 5'd6; tick(); eoi_valid = 0;
    rd(6'd6, d); chk("R8 eoi", d, 0);
    wr(6'd6, 32'hFFFF_FFFF);
    rd(6'd6, d); chk("R9 active ro", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(6'd2, 32'h40);
    offer("R5 line6", 1, 8'd38, 2'd0);
    @(negedge clk);
    irq_ready = 1; bus_valid = 1; bus_write = 1; bus_addr = 6'd2; bus_wdata = 32'h40;
    tick();
    irq_ready = 0; bus_valid = 0; bus_write = 0;
    offer("R2 ack beats set", 0, 0, 0);
    rd(6'd2, d); chk("R2 clear wins", d, 0);
    rd(6'd6, d); chk("R7 active on ack", d, 32'h40);
    wr(6'd2, 32'h40);
    irq_ready = 1; eoi_valid = 1; eoi_id = 5'd6; tick();
    irq_ready = 0; eoi_valid = 0;
    rd(6'd6, d); chk("R8 ack wins", d, 32'h40);
    eoi_valid = 1; tick(); eoi_valid = 0;
    rd(6'd6, d); chk("R8 eoi alone", d, 0);
    wr(6'd1, 32'h40);
  endtask

  task automatic t_secure();
    logic [31:0] d;
    wr(6'd7, 32'h11);
    wr(6'd7, 32'h02);
    rd(6'd7, d); chk("R9 secure", d, 32'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_prio();
    t_arb();
    t_thresh();
    t_wake();
    t_ack();
    t_collide();
    t_secure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule